// File: doc/BRIEF.md
# Unaligned Doubleword Load Merge Unit

This block performs the byte-lane merge for a partial unaligned 64-bit load of the left-half or right-half kind. It receives the low address bits of the access, the naturally aligned 64-bit word fetched from memory, and the current contents of the destination register. It writes back only the register bytes that the access covers. All other register bytes keep their old value; they are neither cleared nor sign-extended.

Two such loads, one of each kind, placed at the two ends of an unaligned doubleword, together assemble the full value. Which bytes are covered depends on a lane index. The lane index is the low three address bits, or their bitwise inverse when the core runs big-endian. The shift amount and the byte mask are formed in combinational logic from that index. The merged value is captured in a register, and a valid flag is raised with it one cycle after the request.

Top module: `lmu_merge_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and `out_data` are 0 after that edge.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low.
- R3: After an edge at which `in_valid` was low, `out_data` keeps its previous value.
- R4: The lane index i equals `in_addr_lo` when `in_big_endian` is 0. When `in_big_endian` is 1, it equals the bitwise inverse of `in_addr_lo`.
- R5: When `in_right` is 0 (left side), register bytes 7-i through 7 are replaced by memory bytes 0 through i, in ascending order. Register bytes 0 through 6-i keep their value. Byte k means bits 8k+7..8k.
- R6: When `in_right` is 1 (right side), register bytes 0 through 7-i are replaced by memory bytes i through 7, in ascending order. Register bytes above 7-i keep their value.
- R7: With left side and i=7, or right side and i=0, `out_data` equals the memory word in full.
- R8: With left side and i=0, only register byte 7 changes, and it takes memory byte 0. With right side and i=7, only register byte 0 changes, and it takes memory byte 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_right | input | 1 | 0 = left-side load, 1 = right-side load |
| in_big_endian | input | 1 | 1 = big-endian core, inverts the address bits |
| in_addr_lo | input | 3 | Low address bits of the access |
| in_mem | input | 64 | Aligned memory word |
| in_rd | input | 64 | Current destination register value |
| out_valid | output | 1 | Merged result valid |
| out_data | output | 64 | Merged register value |

## Verification
Every merged result comes from a single register stage. The value driven before edge N therefore appears on `out_data` and `out_valid` right after edge N. The bench drives inputs on the falling edge, lets one rising edge pass, and samples on the next falling edge. It then drops `in_valid`, waits one more edge, and checks that the valid flag has cleared and the data has held. Expected values come from a byte-by-byte loop model in the bench, which builds each output byte from the lane rules instead of from shifts and masks.

// File: rtl/lmu_pkg.sv
package lmu_pkg;
  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } lmu_side_e;
endpackage

// File: rtl/lmu_lane_index.sv
module lmu_lane_index #(
  parameter int IDX_W = 3
) (
  input  logic             big_endian,
  input  logic [IDX_W-1:0] addr_lo,
  output logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] pivot
);
  localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};

  always_comb begin
    idx   = big_endian ? ~addr_lo : addr_lo;
    pivot = LAST - idx;
  end
endmodule

// File: rtl/lmu_lane_select.sv
module lmu_lane_select #(
  parameter int DATA_W = 64,
  localparam int BYTES = DATA_W / 8,
  localparam int IDX_W = $clog2(BYTES),
  localparam int SH_W  = IDX_W + 3
) (
  input  lmu_pkg::lmu_side_e side,
  input  logic [IDX_W-1:0]   idx,
  input  logic [IDX_W-1:0]   pivot,
  input  logic [DATA_W-1:0]  mem,
  output logic [DATA_W-1:0]  aligned,
  output logic [BYTES-1:0]   lane_en
);
  logic [SH_W-1:0] sh_left;
  logic [SH_W-1:0] sh_right;

  assign sh_left  = {pivot, 3'b000};
  assign sh_right = {idx, 3'b000};

  always_comb begin
    if (side == lmu_pkg::SIDE_RIGHT) aligned = mem >> sh_right;
    else                             aligned = mem << sh_left;
  end

  for (genvar k = 0; k < BYTES; k++) begin : g_lane
    localparam logic [IDX_W-1:0] K = IDX_W'(k);
    assign lane_en[k] = (side == lmu_pkg::SIDE_RIGHT) ? (K <= pivot) : (K >= pivot);
  end
endmodule

// File: rtl/lmu_byte_merge.sv
module lmu_byte_merge #(
  parameter int DATA_W = 64,
  localparam int BYTES = DATA_W / 8
) (
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] new_val,
  input  logic [BYTES-1:0]  lane_en,
  output logic [DATA_W-1:0] merged
);
  for (genvar k = 0; k < BYTES; k++) begin : g_byte
    assign merged[8*k +: 8] = lane_en[k] ? new_val[8*k +: 8] : old_val[8*k +: 8];
  end
endmodule

// File: rtl/lmu_merge_unit.sv
module lmu_merge_unit #(
  parameter int DATA_W = 64,
  localparam int BYTES = DATA_W / 8,
  localparam int IDX_W = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_right,
  input  logic              in_big_endian,
  input  logic [IDX_W-1:0]  in_addr_lo,
  input  logic [DATA_W-1:0] in_mem,
  input  logic [DATA_W-1:0] in_rd,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  lmu_pkg::lmu_side_e side;
  logic [IDX_W-1:0]   idx;
  logic [IDX_W-1:0]   pivot;
  logic [DATA_W-1:0]  aligned;
  logic [BYTES-1:0]   lane_en;
  logic [DATA_W-1:0]  merged;

  assign side = lmu_pkg::lmu_side_e'(in_right);

  lmu_lane_index #(.IDX_W(IDX_W)) u_index (
    .big_endian (in_big_endian),
    .addr_lo    (in_addr_lo),
    .idx        (idx),
    .pivot      (pivot)
  );

  lmu_lane_select #(.DATA_W(DATA_W)) u_select (
    .side    (side),
    .idx     (idx),
    .pivot   (pivot),
    .mem     (in_mem),
    .aligned (aligned),
    .lane_en (lane_en)
  );

  lmu_byte_merge #(.DATA_W(DATA_W)) u_merge (
    .old_val (in_rd),
    .new_val (aligned),
    .lane_en (lane_en),
    .merged  (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= merged;
    end
  end
endmodule

// File: rtl/lmu_merge_unit_chk.sv
module lmu_merge_unit_chk #(
  parameter int DATA_W = 64,
  localparam int BYTES = DATA_W / 8,
  localparam int IDX_W = $clog2(BYTES)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_right,
  input logic              in_big_endian,
  input logic [IDX_W-1:0]  in_addr_lo,
  input logic [DATA_W-1:0] in_mem,
  input logic [DATA_W-1:0] in_rd,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data
);
  localparam logic [IDX_W-1:0] ALL1 = {IDX_W{1'b1}};

  logic full_left;
  logic full_right;
  assign full_left  = !in_right && ((!in_big_endian && in_addr_lo == ALL1) ||
                                    (in_big_endian && in_addr_lo == '0));
  assign full_right = in_right && ((!in_big_endian && in_addr_lo == '0) ||
                                   (in_big_endian && in_addr_lo == ALL1));

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_hold_data_R3: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));

  assert_full_replace_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (full_left || full_right)) |=> out_data == $past(in_mem));

  assert_left_low_kept_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_right && !full_left) |=> out_data[7:0] == $past(in_rd[7:0]));

  assert_right_high_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_right && !full_right) |=> out_data[DATA_W-1 -: 8] == $past(in_rd[DATA_W-1 -: 8]));
endmodule

bind lmu_merge_unit lmu_merge_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/lmu_merge_unit_tb.sv
module lmu_merge_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_right;
  logic        in_big_endian;
  logic [2:0]  in_addr_lo;
  logic [63:0] in_mem;
  logic [63:0] in_rd;
  logic        out_valid;
  logic [63:0] out_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  lmu_merge_unit dut_i (.*);

  function automatic logic [63:0] model(input bit right, input bit be,
                                        input logic [2:0] a,
                                        input logic [63:0] mem, input logic [63:0] rd);
    int i;
    logic [63:0] r;
    i = be ? (7 - int'(a)) : int'(a);
    r = rd;
    for (int k = 0; k < 8; k++) begin
      if (!right && k >= 7 - i) r[8*k +: 8] = mem[8*(k - (7 - i)) +: 8];
      if (right && k <= 7 - i)  r[8*k +: 8] = mem[8*(k + i) +: 8];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one request; result due after one rising edge, then valid must drop and data hold
  task automatic apply(input string req, input bit right, input bit be,
                       input logic [2:0] a, input logic [63:0] mem, input logic [63:0] rd);
    logic [63:0] exp;
    exp = model(right, be, a, mem, rd);
    @(negedge clk);
    in_valid = 1'b1; in_right = right; in_big_endian = be;
    in_addr_lo = a; in_mem = mem; in_rd = rd;
    @(negedge clk);
    check(req, out_data, exp);
    check("R2", {63'd0, out_valid}, 64'd1);
    in_valid = 1'b0; in_mem = ~mem; in_rd = ~rd;
    @(negedge clk);
    check("R2", {63'd0, out_valid}, 64'd0);
    check("R3", out_data, exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check("R1", out_data, 64'd0);
    check("R1", {63'd0, out_valid}, 64'd0);
    rst = 1'b0; in_valid = 1'b0;
  endtask

  task automatic t_sweep(input bit right, input bit be, input string req);
    for (int a = 0; a < 8; a++)
      apply(req, right, be, 3'(a), 64'h8877_6655_4433_2211 ^ (64'(a) << 32),
            64'hF0E1_D2C3_B4A5_9687);
  endtask

  task automatic t_full_replace;
    apply("R7", 1'b0, 1'b0, 3'd7, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R7", out_data, 64'h0123_4567_89AB_CDEF);
    apply("R7", 1'b1, 1'b0, 3'd0, 64'hDEAD_BEEF_CAFE_F00D, 64'h0);
    check("R7", out_data, 64'hDEAD_BEEF_CAFE_F00D);
    apply("R7", 1'b0, 1'b1, 3'd0, 64'h1122_3344_5566_7788, 64'h0);
    check("R7", out_data, 64'h1122_3344_5566_7788);
  endtask

  task automatic t_single_byte;
    apply("R8", 1'b0, 1'b0, 3'd0, 64'h0000_0000_0000_00A5, 64'h1111_1111_1111_1111);
    check("R8", out_data, 64'hA511_1111_1111_1111);
    apply("R8", 1'b1, 1'b0, 3'd7, 64'h5A00_0000_0000_0000, 64'h2222_2222_2222_2222);
    check("R8", out_data, 64'h2222_2222_2222_225A);
    apply("R4", 1'b1, 1'b1, 3'd0, 64'h7700_0000_0000_0000, 64'h3333_3333_3333_3333);
    check("R4", out_data, 64'h3333_3333_3333_3377);
  endtask

  task automatic t_mid_reset;
    apply("R5", 1'b0, 1'b0, 3'd3, 64'h1234_5678_9ABC_DEF0, 64'h0);
    t_reset;
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_right = 1'b0; in_big_endian = 1'b0;
    in_addr_lo = '0; in_mem = '0; in_rd = '0;
    repeat (2) @(negedge clk);
    t_reset;
    t_sweep(1'b0, 1'b0, "R5");
    t_sweep(1'b1, 1'b0, "R6");
    t_sweep(1'b0, 1'b1, "R4");
    t_sweep(1'b1, 1'b1, "R4");
    t_full_replace;
    t_single_byte;
    t_mid_reset;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule